// File: doc/BRIEF.md
# Smart Card Character Receiver with Parity Error Signalling

This block receives asynchronous characters on a shared, open-drain, half-duplex data line of the kind used for the character-oriented protocol between a reader and a smart card. Each bit lasts a fixed number of clock cycles (372 by default) and is sampled once, at the middle of its period. A character is one start bit, eight data bits sent least significant bit first, and one parity bit. The receiver assembles the character and then checks that the eight data bits and the parity bit together contain an even number of ones.

A good character loads the data register, raises a receive-full flag and, when enabled, sends a one-cycle receive interrupt. A bad character leaves the data register and receive-full untouched. It sets a sticky parity-error flag, sends a one-cycle error interrupt when enabled, and asks for retransmission: half a bit after the parity bit ends, the block pulls the shared line low for one bit time through `line_oe`. Reading the data clears receive-full. Software clears the parity-error flag.

The controller moves through six states. IDLE goes to START on a falling edge of the line. START goes back to IDLE if the mid-bit sample is high, which marks a glitch, and otherwise goes to DATA at the end of the bit. DATA goes to PARITY after the eighth data bit. At the end of the parity bit, PARITY goes to IDLE after a good character or to ERR_GAP after a bad one. ERR_GAP goes to ERR_DRIVE after half a bit. ERR_DRIVE goes back to IDLE after one bit.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_data` is 0x00, `rx_full`, `par_err`, `irq_rx`, `irq_err` and `line_oe` are all 0.
- R2: A character (start bit low, eight data bits LSB first, parity bit, each bit CYCLES_PER_BIT cycles) whose nine data-plus-parity bits hold an even number of ones loads `rx_data` with the byte and sets `rx_full`.
- R3: A character with correct parity leaves `par_err` unchanged and keeps `line_oe` at 0 throughout its frame and error slot.
- R4: A character with wrong parity sets `par_err` to 1 and leaves `rx_full` and `rx_data` unchanged.
- R5: After a wrong-parity character, `line_oe` is 1 for exactly CYCLES_PER_BIT cycles. It begins 10.5 bit times plus three clock cycles of input latency after the line falls for the start bit. `line_oe` is 0 at all other times.
- R6: A correct character gives a one-cycle `irq_rx` pulse when `rx_ie` is 1 and no pulse when it is 0.
- R7: A wrong-parity character gives a one-cycle `irq_err` pulse when `rx_ie` is 1 and no pulse when it is 0.
- R8: A one-cycle `rd_strobe` clears `rx_full`. If a new character completes in the same cycle, the flag stays set.
- R9: A one-cycle `par_clr` clears `par_err`. If a new parity error is found in the same cycle, the flag stays set.
- R10: A low pulse shorter than half a bit is rejected at the mid-bit check of the start bit. It changes no flag or data, and the receiver is ready for the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Level of the shared data line |
| line_oe | output | 1 | 1 pulls the shared line low (error signal) |
| rx_ie | input | 1 | Enables the receive and error interrupts |
| rd_strobe | input | 1 | Data read; clears receive-full |
| par_clr | input | 1 | Clears the parity-error flag |
| rx_data | output | 8 | Last correctly received byte |
| rx_full | output | 1 | Receive-data-full flag |
| par_err | output | 1 | Sticky parity-error flag |
| irq_rx | output | 1 | One-cycle receive interrupt request |
| irq_err | output | 1 | One-cycle error interrupt request |

## Verification
The assertions assume the sender follows the line protocol. It holds each bit steady for a full bit period, and it keeps the line released while the receiver drives the error slot, so the only low level seen in ERR_DRIVE is the block's own. They also assume `rd_strobe` and `par_clr` arrive as single-cycle pulses. The stimulus drives every bit for exactly CYCLES_PER_BIT cycles. It models the line as the sender's level ANDed with the inverse of `line_oe`, and it pulses the clears only while no character is being received.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_START     = 3'd1,
        S_DATA      = 3'd2,
        S_PARITY    = 3'd3,
        S_ERR_GAP   = 3'd4,
        S_ERR_DRIVE = 3'd5
    } rx_state_t;
endpackage

// File: rtl/sc_line_sync.sv
module sc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign line_s = sync_q[STAGES-1];
    assign fall   = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sc_bit_timer.sv
module sc_bit_timer #(
    parameter int CYCLES_PER_BIT = 372,
    parameter int CNT_W          = $clog2(CYCLES_PER_BIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             at_mid,
    output logic             at_last,
    output logic             at_half_end
);
    localparam int HALF = CYCLES_PER_BIT / 2;
    localparam logic [CNT_W-1:0] MID_V  = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(CYCLES_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HEND_V = CNT_W'(HALF - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear || cnt == LAST_V)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign at_mid      = (cnt == MID_V);
    assign at_last     = (cnt == LAST_V);
    assign at_half_end = (cnt == HEND_V);

    // R2: counter never leaves the bit period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_V);
    // R2: the counter wraps to zero after the last cycle of a bit
    a_r2_cnt_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        at_last |=> cnt == '0);
endmodule

// File: rtl/sc_char_shift.sv
module sc_char_shift #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [DATA_BITS-1:0] data,
    output logic                 odd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            odd  <= 1'b0;
        end else if (clear) begin
            data <= '0;
            odd  <= 1'b0;
        end else if (shift_en) begin
            data <= {bit_in, data[DATA_BITS-1:1]};
            odd  <= odd ^ bit_in;
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int CYCLES_PER_BIT = 372,
    parameter int DATA_BITS      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    output logic                 line_oe,
    input  logic                 rx_ie,
    input  logic                 rd_strobe,
    input  logic                 par_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 par_err,
    output logic                 irq_rx,
    output logic                 irq_err
);
    localparam int CNT_W = $clog2(CYCLES_PER_BIT);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_t state, state_nx;

    logic                 line_s, fall;
    logic [CNT_W-1:0]     cnt;
    logic                 at_mid, at_last, at_half_end;
    logic                 tmr_clear;
    logic [IDX_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shift_data;
    logic                 shift_odd;
    logic                 frame_bad;
    logic                 par_sample, good_ev, bad_ev;

    sc_line_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    sc_bit_timer #(.CYCLES_PER_BIT(CYCLES_PER_BIT), .CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tmr_clear),
        .cnt        (cnt),
        .at_mid     (at_mid),
        .at_last    (at_last),
        .at_half_end(at_half_end)
    );

    sc_char_shift #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == S_START),
        .shift_en(state == S_DATA && at_mid),
        .bit_in  (line_s),
        .data    (shift_data),
        .odd     (shift_odd)
    );

    assign par_sample = (state == S_PARITY) && at_mid;
    assign good_ev    = par_sample && !(shift_odd ^ line_s);
    assign bad_ev     = par_sample &&  (shift_odd ^ line_s);
    assign tmr_clear  = (state == S_IDLE) || (state_nx != state);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (fall) state_nx = S_START;
            S_START:     if (at_mid && line_s) state_nx = S_IDLE;
                         else if (at_last) state_nx = S_DATA;
            S_DATA:      if (at_last && bit_idx == LAST_IDX) state_nx = S_PARITY;
            S_PARITY:    if (at_last) state_nx = frame_bad ? S_ERR_GAP : S_IDLE;
            S_ERR_GAP:   if (at_half_end) state_nx = S_ERR_DRIVE;
            S_ERR_DRIVE: if (at_last) state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // data-bit index and frame verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx   <= '0;
            frame_bad <= 1'b0;
        end else begin
            if (state != S_DATA)
                bit_idx <= '0;
            else if (at_last)
                bit_idx <= bit_idx + 1'b1;
            if (state == S_START)
                frame_bad <= 1'b0;
            else if (bad_ev)
                frame_bad <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            par_err <= 1'b0;
            irq_rx  <= 1'b0;
            irq_err <= 1'b0;
            line_oe <= 1'b0;
        end else begin
            if (good_ev)
                rx_data <= shift_data;
            if (good_ev)
                rx_full <= 1'b1;
            else if (rd_strobe)
                rx_full <= 1'b0;
            if (bad_ev)
                par_err <= 1'b1;
            else if (par_clr)
                par_err <= 1'b0;
            irq_rx  <= good_ev && rx_ie;
            irq_err <= bad_ev && rx_ie;
            line_oe <= (state_nx == S_ERR_DRIVE);
        end
    end

    // R5: error drive starts with a fresh bit count and only after the gap
    a_r5_oe_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> (state == S_ERR_DRIVE && cnt == '0 && $past(state) == S_ERR_GAP));
    // R5: error drive is released exactly at the end of the drive bit
    a_r5_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERR_DRIVE && at_last) |=> !line_oe);
    // R3: a good verdict never leads into error signalling
    a_r3_good_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        good_ev |=> !frame_bad);
    // R4: a bad character never raises receive-full
    a_r4_no_full_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        bad_ev |=> $stable(rx_data) && (rx_full == $past(rx_full && !rd_strobe)));
    // R6: receive interrupt follows the enable and the full flag
    a_r6_irq_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> ($past(rx_ie) && rx_full && !irq_err));
    // R7: error interrupt follows the enable and the error flag
    a_r7_irq_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ($past(rx_ie) && par_err));
    // R8: a read with no completing character empties the buffer
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !good_ev) |=> !rx_full);
    // R9: a clear with no new error drops the flag
    a_r9_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (par_clr && !bad_ev) |=> !par_err);
    // R10: a high mid-bit start sample returns to idle
    a_r10_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_START && at_mid && line_s) |=> state == S_IDLE);
endmodule

// File: tb/test_sc_char_rx.sv
module test_sc_char_rx;
    localparam int N    = 16;
    localparam int HALF = N / 2;
    localparam int NV   = 6;
    // {byte[7:0], bad_parity, irq_enable, clear_before}
    localparam logic [10:0] VEC [NV] = '{
        {8'hA5, 1'b0, 1'b1, 1'b1},
        {8'h3C, 1'b1, 1'b1, 1'b0},
        {8'h3C, 1'b0, 1'b0, 1'b0},
        {8'h01, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b1, 1'b1},
        {8'h80, 1'b0, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_drv = 1'b1;
    logic rx_ie = 1'b0, rd_strobe = 1'b0, par_clr = 1'b0;
    logic line_oe, rx_full, par_err, irq_rx, irq_err;
    logic [7:0] rx_data;
    logic line_in;

    int checks = 0, failures = 0;
    int n_irq_rx = 0, n_irq_err = 0;

    always #4 clk = ~clk;
    assign line_in = tb_drv & ~line_oe;

    sc_char_rx #(.CYCLES_PER_BIT(N), .DATA_BITS(8)) i_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_oe(line_oe),
        .rx_ie(rx_ie), .rd_strobe(rd_strobe), .par_clr(par_clr),
        .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    always @(negedge clk) begin
        if (rst_n && irq_rx)  n_irq_rx++;
        if (rst_n && irq_err) n_irq_err++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_clears(input bit rd, input bit pc);
        @(negedge clk);
        rd_strobe = rd;
        par_clr   = pc;
        @(negedge clk);
        rd_strobe = 1'b0;
        par_clr   = 1'b0;
    endtask

    // sends one character; returns count of cycles where line_oe was wrong
    task automatic send_frame(input logic [7:0] b, input bit bad, output int oe_bad);
        logic par;
        par = (^b) ^ bad;
        oe_bad = 0;
        for (int k = 0; k < 12 * N; k++) begin
            int bi;
            bit exp_oe;
            @(negedge clk);
            exp_oe = bad && (k >= 10 * N + HALF + 3) && (k <= 11 * N + HALF + 2);
            if (line_oe !== exp_oe) oe_bad++;
            bi = k / N;
            if (bi == 0)      tb_drv = 1'b0;
            else if (bi <= 8) tb_drv = b[bi-1];
            else if (bi == 9) tb_drv = par;
            else              tb_drv = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] e_data;
        bit e_full, e_perr;
        int e_irx, e_ierr, oe_bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rx_data == 8'h00 && !rx_full && !par_err && !irq_rx && !irq_err && !line_oe,
            "R1 reset", {rx_data, rx_full, par_err, line_oe}, 0);

        e_data = 8'h00; e_full = 0; e_perr = 0; e_irx = 0; e_ierr = 0;

        // table walk: R2, R3, R4, R5, R6, R7
        for (int v = 0; v < NV; v++) begin
            logic [7:0] b;
            bit bad, ie, clr;
            {b, bad, ie, clr} = VEC[v];
            if (clr) begin
                pulse_clears(1'b1, 1'b1);
                e_full = 0; e_perr = 0;
            end
            rx_ie = ie;
            send_frame(b, bad, oe_bad);
            if (bad) begin
                e_perr = 1;
                if (ie) e_ierr++;
            end else begin
                e_data = b; e_full = 1;
                if (ie) e_irx++;
            end
            chk(oe_bad == 0, bad ? "R5 error drive window" : "R3 line released", oe_bad, 0);
            chk(rx_data == e_data, bad ? "R4 data kept" : "R2 data", rx_data, e_data);
            chk(rx_full == e_full, bad ? "R4 full kept" : "R2 full", rx_full, e_full);
            chk(par_err == e_perr, bad ? "R4 parity flag" : "R3 parity flag unchanged", par_err, e_perr);
            chk(n_irq_rx == e_irx, "R6 receive irq count", n_irq_rx, e_irx);
            chk(n_irq_err == e_ierr, "R7 error irq count", n_irq_err, e_ierr);
        end

        // R8: read clears receive-full
        pulse_clears(1'b1, 1'b0);
        chk(!rx_full, "R8 read clears full", rx_full, 0);
        chk(rx_data == e_data, "R8 data held after read", rx_data, e_data);

        // R9: parity-error clear
        rx_ie = 1'b1;
        send_frame(8'h55, 1'b1, oe_bad);
        e_ierr++;
        chk(par_err, "R9 flag set before clear", par_err, 1);
        pulse_clears(1'b0, 1'b1);
        chk(!par_err, "R9 clear drops flag", par_err, 0);

        // R10: short glitch rejected
        @(negedge clk);
        tb_drv = 1'b0;
        repeat (3) @(negedge clk);
        tb_drv = 1'b1;
        repeat (2 * N) @(negedge clk);
        chk(!rx_full && !par_err && rx_data == e_data && !line_oe,
            "R10 glitch ignored", {rx_full, par_err, line_oe}, 0);
        chk(n_irq_rx == e_irx && n_irq_err == e_ierr, "R10 no irq on glitch",
            n_irq_rx + n_irq_err, e_irx + e_ierr);
        send_frame(8'hC3, 1'b0, oe_bad);
        e_irx++;
        chk(rx_data == 8'hC3 && rx_full, "R10 next character after glitch", rx_data, 8'hC3);
        chk(n_irq_rx == e_irx, "R6 irq after glitch", n_irq_rx, e_irx);

        // R1: reset mid-life returns to reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_data == 8'h00 && !rx_full && !par_err && !line_oe, "R1 second reset",
            {rx_data, rx_full, par_err}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule